// File: doc/BRIEF.md
# External Event Timestamp Capture Unit

This block watches one pin out of a bank of external inputs and, whenever that pin shows a qualifying transition, records the free-running time-of-day value supplied by a separate time counter. Each accepted event also advances an event counter and sets a status flag. The flag drives an interrupt line toward the host through a mask bit. The host clears the flag by issuing a read strobe on the alarm status location.

Software sets the block up with a single configuration word. That word holds a capture enable, a two-bit edge mode (rising, falling, both, or off) and a pin selector. The selected pin is brought into the clock domain through a synchronizer before edges are detected. The time value is taken in the same cycle the edge is recognised. Whenever a new event arrives, it replaces the stored time, even if the host has not yet read the previous one.

Top module: `evt_stamp_capture`

## Requirements
- R1: After reset the captured time, the event count and the interrupt line are all zero.
- R2: While configuration bit 0 (capture enable) is 0, no edge changes the count, the time or the status.
- R3: Edge mode 0 (configuration bits [2:1]) captures rising edges of the selected pin only; falling edges are ignored.
- R4: Edge mode 1 captures falling edges only; edge mode 2 captures both rising and falling edges.
- R5: Edge mode 3 captures nothing.
- R6: Configuration bits [12:8] choose the monitored pin; edges on any other pin are ignored.
- R7: A pin change present before clock edge E0 is captured at edge E2. The stored time is the live time value sampled at E2. Count and time outputs change after E2, and not before.
- R8: Each capture adds exactly one to the event count, which wraps from its maximum value to zero.
- R9: A second capture overwrites the stored time, even if the status was never cleared.
- R10: A capture sets the status. The interrupt line equals that status ANDed with bit 0 of the mask register. Setting the mask after an event raises the line for a status that is still pending.
- R11: A one-cycle alarm read strobe clears the status at the next clock edge. If a capture falls in that same cycle, the status stays set.
- R12: A register write to address 0 loads the configuration, and a write to address 1 loads the mask. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | NUM_PINS (32) | Bank of asynchronous external event pins |
| now_i | input | TIME_W (64) | Live time-of-day from the time counter |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (2) | Register write address: 0 configuration, 1 mask |
| reg_wdata_i | input | DATA_W (32) | Register write data |
| alarm_rd_i | input | 1 | Host read strobe of the alarm status; clears the status |
| evt_time_o | output | TIME_W (64) | Time of the most recent capture |
| evt_count_o | output | CNT_W (32) | Number of captures, modulo 2^CNT_W |
| irq_o | output | 1 | Masked event interrupt |

## Verification
The bench targets the exact capture cycle. A synchronizer that is one stage short or long shifts the stored time by one step of the live time, and the count moves one cycle early or late. Each edge mode is exercised against both transition directions, so a swapped polarity decode fails. Edges on unselected pins and on selector value 31 would expose a pin multiplexer that is wired wrong. The bench also places an alarm read in the exact cycle of a capture, which reveals a clear that takes priority over the set and drops an event. Finally, it runs the counter past its top value with a narrow count width, which exposes a counter that saturates instead of wrapping.

// File: rtl/evt_cap_pkg.sv
package evt_cap_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_OFF  = 2'd3
  } edge_mode_e;

  // configuration word field positions
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_MODE_LSB = 1;
  localparam int CFG_SEL_LSB  = 8;
  localparam int CFG_SEL_MAX  = 5;

  // mask word field position
  localparam int MASK_IRQ_BIT = 0;

  // register addresses
  localparam int ADDR_CFG  = 0;
  localparam int ADDR_MASK = 1;

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_cap_pkg::*;
#(
  parameter int SEL_W  = 5,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output edge_mode_e        mode_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              irq_mask_o
);

  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADDR_CFG);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);

  logic             en_q, en_d;
  edge_mode_e       mode_q, mode_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             mask_q, mask_d;
  logic             cfg_we, mask_we;

  always_comb begin
    cfg_we  = wr_i && (addr_i == A_CFG);
    mask_we = wr_i && (addr_i == A_MASK);
    en_d    = wdata_i[CFG_EN_BIT];
    mode_d  = edge_mode_e'(wdata_i[CFG_MODE_LSB +: 2]);
    sel_d   = wdata_i[CFG_SEL_LSB +: SEL_W];
    mask_d  = wdata_i[MASK_IRQ_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= EDGE_RISE;
      sel_q  <= '0;
    end else if (cfg_we) begin
      en_q   <= en_d;
      mode_q <= mode_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  assign en_o       = en_q;
  assign mode_o     = mode_q;
  assign sel_o      = sel_q;
  assign irq_mask_o = mask_q;

endmodule

// File: rtl/evt_pin_frontend.sv
module evt_pin_frontend
  import evt_cap_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SEL_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                en_i,
  input  edge_mode_e          mode_i,
  output logic                hit_o
);

  // synchronizer stages plus one history stage for edge detection
  localparam int CHAIN = SYNC_STAGES + 1;

  logic             pin_raw;
  logic [CHAIN-1:0] chain_q, chain_d;
  logic             cur, prev;
  logic             rise, fall;
  logic             hit;

  always_comb begin
    pin_raw = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (sel_i == SEL_W'(i)) pin_raw = pins_i[i];
    end
  end

  always_comb begin
    chain_d = {chain_q[CHAIN-2:0], pin_raw};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  always_comb begin
    cur  = chain_q[SYNC_STAGES-1];
    prev = chain_q[SYNC_STAGES];
    rise = cur & ~prev;
    fall = ~cur & prev;
    unique case (mode_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    hit_o = en_i & hit;
  end

endmodule

// File: rtl/evt_capture_core.sv
module evt_capture_core #(
  parameter int TIME_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [TIME_W-1:0] now_i,
  input  logic              alarm_rd_i,
  output logic [TIME_W-1:0] time_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              status_o
);

  logic [TIME_W-1:0] time_q, time_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              st_q, st_d;
  logic              st_we;

  always_comb begin
    time_d = now_i;
    cnt_d  = cnt_q + CNT_W'(1);
    st_we  = hit_i | alarm_rd_i;
    // a capture in the clearing cycle keeps the status set
    st_d   = hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      cnt_q  <= '0;
    end else if (hit_i) begin
      time_q <= time_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= 1'b0;
    end else if (st_we) begin
      st_q <= st_d;
    end
  end

  assign time_o   = time_q;
  assign count_o  = cnt_q;
  assign status_o = st_q;

endmodule

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture
  import evt_cap_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int TIME_W      = 64,
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [TIME_W-1:0]   now_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  input  logic                alarm_rd_i,
  output logic [TIME_W-1:0]   evt_time_o,
  output logic [CNT_W-1:0]    evt_count_o,
  output logic                irq_o
);

  localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic             rst_sync_n;
  logic             cfg_en;
  edge_mode_e       cfg_mode;
  logic [SEL_W-1:0] cfg_sel;
  logic             irq_mask;
  logic             evt_hit;
  logic             evt_status;

  evt_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  evt_cfg_regs #(
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .en_o       (cfg_en),
    .mode_o     (cfg_mode),
    .sel_o      (cfg_sel),
    .irq_mask_o (irq_mask)
  );

  evt_pin_frontend #(
    .NUM_PINS    (NUM_PINS),
    .SEL_W       (SEL_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .pins_i (pins_i),
    .sel_i  (cfg_sel),
    .en_i   (cfg_en),
    .mode_i (cfg_mode),
    .hit_o  (evt_hit)
  );

  evt_capture_core #(
    .TIME_W (TIME_W),
    .CNT_W  (CNT_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .hit_i      (evt_hit),
    .now_i      (now_i),
    .alarm_rd_i (alarm_rd_i),
    .time_o     (evt_time_o),
    .count_o    (evt_count_o),
    .status_o   (evt_status)
  );

  assign irq_o = evt_status & irq_mask;

endmodule

// File: rtl/evt_cap_chk.sv
module evt_cap_chk #(
  parameter int TIME_W = 64,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit,
  input logic              en,
  input logic [1:0]        mode,
  input logic              alarm_rd,
  input logic              status,
  input logic [TIME_W-1:0] ts,
  input logic [CNT_W-1:0]  cnt
);

  // R2: disabled capture leaves the count untouched
  assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));

  // R5: mode 3 never captures
  assert_mode_off_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> $stable(cnt));

  // R8: the count only ever moves by one
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + CNT_W'(1)));

  // R9: the stored time changes only together with a new capture
  assert_time_with_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ts) |-> !$stable(cnt));

  // R10: a capture leaves the status set
  assert_hit_sets_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status);

  // R11: a read without a coincident capture clears the status
  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_rd && !hit) |=> !status);

endmodule

bind evt_stamp_capture evt_cap_chk #(
  .TIME_W (TIME_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_sync_n),
  .hit      (evt_hit),
  .en       (cfg_en),
  .mode     (cfg_mode),
  .alarm_rd (alarm_rd_i),
  .status   (evt_status),
  .ts       (evt_time_o),
  .cnt      (evt_count_o)
);

// File: tb/evt_stamp_capture_tb.sv
`timescale 1ns/1ps
module evt_stamp_capture_tb;

  localparam int NP    = 32;
  localparam int TW    = 64;
  localparam int CW    = 4;
  localparam int AW    = 2;
  localparam int DW    = 32;
  localparam logic [63:0] STEP = 64'd8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [TW-1:0] now = 64'hFFFF_FFF0_0000_0000;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ard = 1'b0;
  logic [TW-1:0] evt_time;
  logic [CW-1:0] evt_count;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) now <= now + STEP;

  evt_stamp_capture #(
    .NUM_PINS (NP), .TIME_W (TW), .CNT_W (CW), .ADDR_W (AW), .DATA_W (DW)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .pins_i (pins), .now_i (now),
    .reg_wr_i (wr), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .alarm_rd_i (ard), .evt_time_o (evt_time), .evt_count_o (evt_count),
    .irq_o (irq)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgw(bit en, int mode, int sel);
    return (32'(sel) << 8) | (32'(mode) << 1) | 32'(en);
  endfunction

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic alarm_read();
    @(negedge clk);
    ard = 1'b1;
    @(negedge clk);
    ard = 1'b0;
  endtask

  // drive a pin and wait until a capture would be visible
  task automatic set_pin(int idx, logic v, output logic [63:0] t_exp);
    @(negedge clk);
    pins[idx] = v;
    t_exp = now + 2 * STEP;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_event(string req, logic [63:0] t_exp);
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    chk(req, "count", 64'(evt_count), 64'(exp_cnt));
    chk(req, "time", evt_time, t_exp);
  endtask

  task automatic expect_none(string req);
    chk(req, "count unchanged", 64'(evt_count), 64'(exp_cnt));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "time", evt_time, 64'd0);
    chk("R1", "count", 64'(evt_count), 64'd0);
    chk("R1", "irq", 64'(irq), 64'd0);
  endtask

  task automatic t_rising_latency();
    logic [63:0] t;
    wr_reg(1, 32'h1);
    wr_reg(0, cfgw(1, 0, 5));
    @(negedge clk);
    pins[5] = 1'b1;
    t = now + 2 * STEP;
    repeat (2) @(negedge clk);
    chk("R7", "count before capture edge", 64'(evt_count), 64'(exp_cnt));
    @(negedge clk);
    expect_event("R7", t);
    chk("R10", "irq after capture", 64'(irq), 64'd1);
    set_pin(5, 1'b0, t);
    expect_none("R3");
  endtask

  task automatic t_clear();
    alarm_read();
    chk("R11", "irq after alarm read", 64'(irq), 64'd0);
  endtask

  task automatic t_select();
    logic [63:0] t;
    set_pin(4, 1'b1, t);
    set_pin(6, 1'b1, t);
    expect_none("R6");
    pins[4] = 1'b0; pins[6] = 1'b0;
    wr_reg(0, cfgw(1, 0, 31));
    repeat (3) @(negedge clk);
    expect_none("R6");
    set_pin(31, 1'b1, t);
    expect_event("R6", t);
    set_pin(31, 1'b0, t);
    expect_none("R3");
  endtask

  task automatic t_fall_both();
    logic [63:0] t;
    wr_reg(0, cfgw(1, 1, 31));
    set_pin(31, 1'b1, t);
    expect_none("R4");
    set_pin(31, 1'b0, t);
    expect_event("R4", t);
    wr_reg(0, cfgw(1, 2, 31));
    set_pin(31, 1'b1, t);
    expect_event("R4", t);
    set_pin(31, 1'b0, t);
    expect_event("R4", t);
  endtask

  task automatic t_mode_off();
    logic [63:0] t;
    wr_reg(0, cfgw(1, 3, 31));
    set_pin(31, 1'b1, t);
    set_pin(31, 1'b0, t);
    expect_none("R5");
  endtask

  task automatic t_disable();
    logic [63:0] t;
    wr_reg(0, cfgw(0, 2, 31));
    set_pin(31, 1'b1, t);
    set_pin(31, 1'b0, t);
    expect_none("R2");
  endtask

  task automatic t_mask();
    logic [63:0] t;
    alarm_read();
    wr_reg(1, 32'h0);
    wr_reg(0, cfgw(1, 0, 31));
    set_pin(31, 1'b1, t);
    expect_event("R10", t);
    chk("R10", "irq masked", 64'(irq), 64'd0);
    wr_reg(1, 32'h1);
    chk("R10", "irq after unmask", 64'(irq), 64'd1);
    set_pin(31, 1'b0, t);
  endtask

  task automatic t_overwrite();
    logic [63:0] t;
    wr_reg(0, cfgw(1, 2, 31));
    set_pin(31, 1'b1, t);
    expect_event("R9", t);
    set_pin(31, 1'b0, t);
    expect_event("R9", t);
    chk("R9", "irq still pending", 64'(irq), 64'd1);
  endtask

  task automatic t_collide();
    logic [63:0] t;
    alarm_read();
    chk("R11", "irq cleared", 64'(irq), 64'd0);
    @(negedge clk);
    pins[31] = 1'b1;
    t = now + 2 * STEP;
    @(negedge clk);
    @(negedge clk);
    ard = 1'b1;
    @(negedge clk);
    ard = 1'b0;
    expect_event("R11", t);
    chk("R11", "status kept on coincident capture", 64'(irq), 64'd1);
    alarm_read();
    chk("R11", "irq cleared after second read", 64'(irq), 64'd0);
    set_pin(31, 1'b0, t);
    exp_cnt = (exp_cnt + 1) % (1 << CW);
  endtask

  task automatic t_addr();
    logic [63:0] t;
    wr_reg(2, 32'h0);
    wr_reg(3, 32'h0);
    set_pin(31, 1'b1, t);
    expect_event("R12", t);
    chk("R12", "mask unchanged", 64'(irq), 64'd1);
    set_pin(31, 1'b0, t);
    expect_event("R12", t);
  endtask

  task automatic t_wrap();
    logic [63:0] t;
    for (int k = 0; k < 18; k++) begin
      set_pin(31, (k % 2 == 0) ? 1'b1 : 1'b0, t);
      expect_event("R8", t);
    end
  endtask

  initial begin
    t_reset();
    t_rising_latency();
    t_clear();
    t_select();
    t_fall_both();
    t_mode_off();
    t_disable();
    t_mask();
    t_overwrite();
    t_collide();
    t_addr();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule